// File: doc/BRIEF.md
# Dual-Key Register Write Guard

This block is a write-protection gate for the register space of a real-time clock. It sits between a simple register bus and the register file. Reads always pass through. A write passes through only when software has first loaded two 32-bit magic words into two dedicated key slots. A write of any other value to either slot, zero included, closes the gate again in the next cycle.

The gate keeps the key slots itself. A key-slot write is never forwarded to the register file. Any other address is protected: a write there while the gate is closed is dropped, and the bus still completes it normally. The `locked` output shows the gate state, so a power-management or debug agent can observe it.

Top module: `wp_key_gate`

## Requirements
- R1: After synchronous reset, `locked` is 1 and both key slots are cleared. Loading only one correct key after reset does not open the gate.
- R2: The gate is open (`locked` = 0) exactly when slot 0 at byte offset 0x6C last received 0x83E70B13 and slot 1 at offset 0x70 last received 0x95A4F1E0. The two keys may be loaded in either order.
- R3: A write of any other value to either slot, zero or a near-miss of the key, sets `locked` back to 1 in the cycle after that write.
- R4: A write to any address other than 0x6C or 0x70 while `locked` is 1 leaves `reg_wr_en` at 0, and the write is dropped.
- R5: A write to any address other than 0x6C or 0x70 while `locked` is 0 raises `reg_wr_en` in the same cycle as `bus_wr`.
- R6: Writes to 0x6C and 0x70 are accepted in either state and never raise `reg_wr_en`.
- R7: `reg_rd_en` follows `bus_rd` in the same cycle, whatever the gate state.
- R8: `bus_ack` is 1 in the cycle after every read or write, blocked writes included, and 0 otherwise.
- R9: `locked` changes only in the cycle after a key-slot write or after reset. An open gate stays open across writes and reads to other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request from the bus |
| bus_rd | input | 1 | Read request from the bus |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| reg_wr_en | output | 1 | Write strobe passed on to the register file |
| reg_rd_en | output | 1 | Read strobe passed on to the register file |
| bus_ack | output | 1 | Access completion, one cycle after the request |
| locked | output | 1 | 1 while protected writes are blocked |

## Verification
The gate holds only two flags: one match bit per key slot. A wrong flag appears at `locked` one cycle after the key write that set it. It then appears again at `reg_wr_en` on the next protected write, where the write is either forwarded or dropped. A slot that fails to clear on reset, or that keeps a stale match after a wrong value, is caught by loading a single key and watching `locked` stay at 1. A decode fault that forwards key-slot writes, or blocks reads, shows up in the same cycle on `reg_wr_en` or `reg_rd_en`.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_KEYS = 2;

    typedef logic [WORD_W-1:0] word_t;

    // Gate state as seen by the rest of the block
    typedef enum logic {
        GATE_OPEN   = 1'b0,
        GATE_CLOSED = 1'b1
    } gate_e;

    // Per-access request bundle
    typedef struct packed {
        logic  wr;
        logic  rd;
        word_t data;
    } req_t;

    // Byte offset of each key slot
    function automatic logic [15:0] key_offset(input int idx);
        case (idx)
            0:       return 16'h006C;
            default: return 16'h0070;
        endcase
    endfunction

    // Magic word expected in each key slot
    function automatic word_t key_value(input int idx);
        case (idx)
            0:       return 32'h83E7_0B13;
            default: return 32'h95A4_F1E0;
        endcase
    endfunction

endpackage

// File: rtl/wpg_addr_dec.sv
module wpg_addr_dec
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_KEYS-1:0] slot_sel,
    output logic                is_slot
);

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(key_offset(g));
        assign slot_sel[g] = (addr == OFF);
    end

    assign is_slot = |slot_sel;

endmodule

// File: rtl/wpg_key_slot.sv
module wpg_key_slot
    import wpg_pkg::*;
#(
    parameter word_t KEY = 32'h0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_sel,
    input  word_t wdata,
    output logic  match
);

    logic match_q;

    // Keep only the comparison result, not the written word
    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
        end else if (wr_sel) begin
            match_q <= (wdata == KEY);
        end
    end

    assign match = match_q;

    AST_SLOT_CLEAR: assert property (@(posedge clk) $past(rst) |-> !match_q); // R1
    AST_BAD_KEY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wdata != KEY) |=> !match_q); // R3
    AST_GOOD_KEY_SETS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wdata == KEY) |=> match_q); // R2

endmodule

// File: rtl/wpg_fwd.sv
module wpg_fwd
    import wpg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  req_t  req,
    input  logic  is_slot,
    input  gate_e gate,
    output logic  reg_wr_en,
    output logic  reg_rd_en,
    output logic  bus_ack
);

    logic ack_q;

    always_comb begin
        reg_wr_en = req.wr && !is_slot && (gate == GATE_OPEN);
        reg_rd_en = req.rd;
    end

    // Every access completes one cycle later, forwarded or not
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= req.wr || req.rd;
        end
    end

    assign bus_ack = ack_q;

    AST_CLOSED_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (gate == GATE_CLOSED) |-> !reg_wr_en); // R4
    AST_SLOT_NOT_FWD: assert property (@(posedge clk) disable iff (rst)
        is_slot |-> !reg_wr_en); // R6
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (req.wr || req.rd) |=> bus_ack); // R8
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
        !(req.wr || req.rd) |=> !bus_ack); // R8

endmodule

// File: rtl/wp_key_gate.sv
module wp_key_gate
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic              bus_ack,
    output logic              locked
);

    logic [NUM_KEYS-1:0] slot_sel;
    logic [NUM_KEYS-1:0] slot_match;
    logic                is_slot;
    gate_e               gate;
    req_t                req;

    assign req = '{wr: bus_wr, rd: bus_rd, data: bus_wdata};

    wpg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .slot_sel (slot_sel),
        .is_slot  (is_slot)
    );

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slot
        wpg_key_slot #(.KEY(key_value(g))) u_slot (
            .clk    (clk),
            .rst    (rst),
            .wr_sel (bus_wr && slot_sel[g]),
            .wdata  (bus_wdata),
            .match  (slot_match[g])
        );
    end

    assign gate   = (&slot_match) ? GATE_OPEN : GATE_CLOSED;
    assign locked = (gate == GATE_CLOSED);

    wpg_fwd u_fwd (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .is_slot   (is_slot),
        .gate      (gate),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .bus_ack   (bus_ack)
    );

    AST_RESET_LOCKS: assert property (@(posedge clk) $past(rst) |-> locked); // R1
    AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!locked && !(bus_wr && is_slot)) |=> !locked); // R9
    AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (locked && !(bus_wr && is_slot)) |=> locked); // R9

endmodule

// File: tb/wp_key_gate_bench.sv
module wp_key_gate_bench;

    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;
    localparam int NV = 14;

    // {wr, rd, addr[7:0], data[31:0], exp_wr_en, exp_rd_en, exp_locked_after}
    localparam logic [44:0] VEC [0:NV-1] = '{
        {1'b1, 1'b0, 8'h00, 32'h0000_0005, 1'b0, 1'b0, 1'b1}, // R4 closed write dropped
        {1'b1, 1'b0, 8'h6C, K0,            1'b0, 1'b0, 1'b1}, // R6 one key only
        {1'b0, 1'b1, 8'h00, 32'h0,         1'b0, 1'b1, 1'b1}, // R7 read while closed
        {1'b1, 1'b0, 8'h70, K1,            1'b0, 1'b0, 1'b0}, // R2 both keys open
        {1'b1, 1'b0, 8'h04, 32'h0000_0012, 1'b1, 1'b0, 1'b0}, // R5 forwarded
        {1'b0, 1'b1, 8'h44, 32'h0,         1'b0, 1'b1, 1'b0}, // R7 read while open
        {1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b0}, // R9 idle keeps open
        {1'b1, 1'b0, 8'h70, 32'h95A4_F1E1, 1'b0, 1'b0, 1'b1}, // R3 near-miss relocks
        {1'b1, 1'b0, 8'h08, 32'h0000_0001, 1'b0, 1'b0, 1'b1}, // R4 dropped again
        {1'b1, 1'b0, 8'h70, K1,            1'b0, 1'b0, 1'b0}, // R2 reopen
        {1'b1, 1'b0, 8'h6C, 32'h0,         1'b0, 1'b0, 1'b1}, // R3 zero relocks
        {1'b1, 1'b0, 8'h6C, K0,            1'b0, 1'b0, 1'b0}, // R2 slot 1 kept key
        {1'b1, 1'b0, 8'hFC, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0}, // R5 top address
        {1'b1, 1'b0, 8'h70, 32'h0,         1'b0, 1'b0, 1'b1}  // R3 zero on slot 1
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        reg_wr_en, reg_rd_en, bus_ack, locked;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wp_key_gate #(.ADDR_W(8)) u_wp_key_gate (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .bus_ack(bus_ack), .locked(locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, check strobes shortly after,
    // then check registered outputs at the next falling edge.
    task automatic access(input logic wr, input logic rd, input logic [7:0] a,
                          input logic [31:0] d, input logic ewr, input logic erd,
                          input logic elock, input string tag);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        chk({tag, " reg_wr_en"}, 32'(reg_wr_en), 32'(ewr));
        chk({tag, " reg_rd_en"}, 32'(reg_rd_en), 32'(erd));
        @(negedge clk);
        chk({tag, " locked"}, 32'(locked), 32'(elock));
        chk("R8 bus_ack", 32'(bus_ack), 32'(wr | rd));
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 locked after reset", 32'(locked), 32'd1);
        chk("R8 no ack after reset", 32'(bus_ack), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [44:0] v;
            v = VEC[i];
            access(v[44], v[43], v[42:35], v[34:3], v[2], v[1], v[0],
                   $sformatf("vec%0d", i));
        end

        // R1: reset from the open state clears both slots
        access(1'b1, 1'b0, 8'h6C, K0, 1'b0, 1'b0, 1'b1, "R1 prep k0");
        access(1'b1, 1'b0, 8'h70, K1, 1'b0, 1'b0, 1'b0, "R1 prep k1");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 locked after mid-run reset", 32'(locked), 32'd1);
        access(1'b1, 1'b0, 8'h70, K1, 1'b0, 1'b0, 1'b1, "R1 slot0 cleared");
        access(1'b1, 1'b0, 8'h10, 32'h7, 1'b0, 1'b0, 1'b1, "R4 after reset");
        // R2: keys in the other order
        access(1'b1, 1'b0, 8'h6C, K0, 1'b0, 1'b0, 1'b0, "R2 reverse order");
        access(1'b1, 1'b1, 8'h14, 32'h9, 1'b1, 1'b1, 1'b0, "R5 R7 write+read");
        // R3: correct key in the wrong slot relocks
        access(1'b1, 1'b0, 8'h6C, K1, 1'b0, 1'b0, 1'b1, "R3 swapped key");
        access(1'b0, 1'b1, 8'h6C, 32'h0, 1'b0, 1'b1, 1'b1, "R7 read slot addr");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule